// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Register Reader

This block sits on the host side of a pseudo-static RAM bus. It reads one of the memory's three internal configuration registers and then hands the bus back for ordinary array traffic. A request carries a two-bit register selector and a mode flag. In asynchronous mode each phase is timed by a cycle counter. In clocked mode the block counts a programmed latency and also follows the memory's active-low WAIT output, which may stretch the access after a refresh collision.

The configuration space is reached by raising the configuration-enable pin while the address is latched. The register is chosen by a two-bit code on address lines 19:18. The block never writes, so the write enable stays high and the data bus is only an input. The 16-bit result comes back with a one-cycle valid strobe. A selector that names no register is refused with an error flag, and it causes no bus access.

Top module: `psram_cfg_reader`

## Requirements
- R1: While reset is held, and right after it, the bus is idle: chip select, address-valid, output enable, write enable and both byte enables are high, configuration enable is low, the address is zero, `rsp_valid` is low and `req_ready` is high.
- R2: Selector encoding: `req_sel` 0 reads the refresh configuration register (code 00 on `mem_addr[19:18]`), 1 reads the bus configuration register (code 10), and 2 reads the device identification register (code 01). All other address bits are zero throughout the access.
- R3: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the release phase ends, and `req_valid` during that time has no effect on the bus or the response.
- R4: Asynchronous mode (`req_sync`=0): for ADV_CYC cycles chip select and address-valid are low, configuration enable is high and output enable is high. Then for ACC_CYC cycles address-valid is high while output enable and both byte enables are low. DQ is captured at the edge that ends the last of these cycles.
- R5: Clocked mode (`req_sync`=1): for one cycle chip select and address-valid are low with configuration enable high, so the memory latches the address. Then chip select, output enable and both byte enables stay low for LATENCY cycles. DQ is captured at the edge that ends the LATENCY-th cycle if `mem_wait_n` is high there.
- R6: In clocked mode, each edge at the end of the latency count where `mem_wait_n` is low (WAIT asserted) adds one cycle with chip select still low. DQ is never captured while WAIT is asserted.
- R7: After capture, chip select, output enable and byte enables go high and configuration enable goes low for REC_CYC cycles. `rsp_valid` pulses for exactly the first of them, with the captured value on `rsp_data` and `rsp_err` low. `rsp_data` is zero whenever `rsp_valid` is low.
- R8: An accepted selector of 3 drives no bus pin. In the next cycle `rsp_valid` and `rsp_err` are high, `rsp_data` is zero and `req_ready` is low. `req_ready` returns high one cycle later.
- R9: `mem_we_n` is high at all times. The block has no data output toward the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; also the memory clock in clocked mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_sel | input | 2 | Register selector (0 refresh cfg, 1 bus cfg, 2 device id, 3 invalid) |
| req_sync | input | 1 | 1 = clocked burst access, 0 = asynchronous access |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_err | output | 1 | Request refused (invalid selector) |
| rsp_data | output | DATA_W | Captured register value |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cre | output | 1 | Configuration-register enable, active high |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low, held high |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_dq_in | input | DATA_W | Data bus from the memory |
| mem_wait_n | input | 1 | Memory WAIT, low while data is not ready |

## Verification
The bench builds the block with ADV_CYC=2, ACC_CYC=3, LATENCY=3 and REC_CYC=2. Because every phase then lasts more than one cycle, an off-by-one in any counter shifts a pin edge that the per-cycle reference comparison can see. The memory model presents the correct data only in the final access cycle, or only while WAIT is released, so a capture one cycle early returns a marker value. Clocked reads run with zero, one and two extra WAIT cycles. These settings also allow a request to be raised in the middle of a long access, to show that it is ignored.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AADV,
        ST_AACC,
        ST_SADV,
        ST_SLAT,
        ST_REL,
        ST_ERR
    } rd_state_e;

    typedef enum logic [1:0] {
        SEL_REFRESH = 2'd0,
        SEL_BUSCFG  = 2'd1,
        SEL_DEVID   = 2'd2,
        SEL_BAD     = 2'd3
    } cfg_sel_e;

    // Bus codes placed on the two register-select address lines.
    localparam logic [1:0] CODE_REFRESH = 2'b00;
    localparam logic [1:0] CODE_BUSCFG  = 2'b10;
    localparam logic [1:0] CODE_DEVID   = 2'b01;

    typedef struct packed {
        logic cs_n;
        logic adv_n;
        logic oe_n;
        logic cre;
        logic bytes_n;
    } pin_set_t;

    localparam pin_set_t PINS_IDLE = '{cs_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1, cre: 1'b0, bytes_n: 1'b1};

    // Control pin levels that belong to each controller state.
    function automatic pin_set_t pins_of(rd_state_e s);
        pin_set_t p;
        p = PINS_IDLE;
        case (s)
            ST_AADV, ST_SADV: begin
                p.cs_n  = 1'b0;
                p.adv_n = 1'b0;
                p.cre   = 1'b1;
            end
            ST_AACC, ST_SLAT: begin
                p.cs_n    = 1'b0;
                p.oe_n    = 1'b0;
                p.cre     = 1'b1;
                p.bytes_n = 1'b0;
            end
            default: p = PINS_IDLE;
        endcase
        return p;
    endfunction

    function automatic logic is_cfg_phase(rd_state_e s);
        return (s == ST_AADV) || (s == ST_AACC) || (s == ST_SADV) || (s == ST_SLAT);
    endfunction

endpackage

// File: rtl/cfg_sel_decode.sv
module cfg_sel_decode
    import psram_cfg_pkg::*;
(
    input  logic [1:0] sel,
    output logic [1:0] code,
    output logic       bad
);

    always_comb begin
        code = CODE_REFRESH;
        bad  = 1'b0;
        case (cfg_sel_e'(sel))
            SEL_REFRESH: code = CODE_REFRESH;
            SEL_BUSCFG:  code = CODE_BUSCFG;
            SEL_DEVID:   code = CODE_DEVID;
            default:     bad  = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/psram_cfg_reader.sv
module psram_cfg_reader
    import psram_cfg_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int SEL_LSB = 18,
    parameter int ADV_CYC = 1,
    parameter int ACC_CYC = 5,
    parameter int LATENCY = 3,
    parameter int REC_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_sel,
    input  logic              req_sync,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cre,
    output logic              mem_adv_n,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    input  logic [DATA_W-1:0] mem_dq_in,
    input  logic              mem_wait_n
);

    localparam int LONG_AB = (ADV_CYC > ACC_CYC) ? ADV_CYC : ACC_CYC;
    localparam int LONG_LR = (LATENCY > REC_CYC) ? LATENCY : REC_CYC;
    localparam int LONGEST = (LONG_AB > LONG_LR) ? LONG_AB : LONG_LR;
    localparam int CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

    localparam logic [CNT_W-1:0] LD_ADV = CNT_W'(ADV_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_LAT = CNT_W'(LATENCY - 1);
    localparam logic [CNT_W-1:0] LD_REC = CNT_W'(REC_CYC - 1);

    typedef struct packed {
        rd_state_e         st;
        logic [1:0]        code;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_data;
        pin_set_t          pins;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:        ST_IDLE,
        code:      2'b00,
        rsp_valid: 1'b0,
        rsp_err:   1'b0,
        rsp_data:  '0,
        pins:      PINS_IDLE,
        addr:      '0
    };

    ctl_t             ctl_d, ctl_q;
    logic [1:0]       dec_code;
    logic             dec_bad;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    cfg_sel_decode u_dec (
        .sel  (req_sel),
        .code (dec_code),
        .bad  (dec_bad)
    );

    cfg_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.rsp_err   = 1'b0;
        ctl_d.rsp_data  = '0;
        tmr_load        = 1'b0;
        tmr_val         = '0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_bad) begin
                        ctl_d.st        = ST_ERR;
                        ctl_d.rsp_valid = 1'b1;
                        ctl_d.rsp_err   = 1'b1;
                    end else begin
                        ctl_d.code = dec_code;
                        if (req_sync) begin
                            ctl_d.st = ST_SADV;
                        end else begin
                            ctl_d.st = ST_AADV;
                            tmr_load = 1'b1;
                            tmr_val  = LD_ADV;
                        end
                    end
                end
            end
            ST_AADV: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_AACC;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACC;
                end
            end
            ST_AACC: begin
                if (tmr_zero) begin
                    ctl_d.st        = ST_REL;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = mem_dq_in;
                    tmr_load        = 1'b1;
                    tmr_val         = LD_REC;
                end
            end
            ST_SADV: begin
                ctl_d.st = ST_SLAT;
                tmr_load = 1'b1;
                tmr_val  = LD_LAT;
            end
            ST_SLAT: begin
                // Latency spent: capture only once WAIT has been released.
                if (tmr_zero && mem_wait_n) begin
                    ctl_d.st        = ST_REL;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = mem_dq_in;
                    tmr_load        = 1'b1;
                    tmr_val         = LD_REC;
                end
            end
            ST_REL: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_ERR: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase

        ctl_d.pins = pins_of(ctl_d.st);
        ctl_d.addr = '0;
        if (is_cfg_phase(ctl_d.st)) begin
            ctl_d.addr[SEL_LSB +: 2] = ctl_d.code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_err   = ctl_q.rsp_err;
    assign rsp_data  = ctl_q.rsp_data;
    assign mem_addr  = ctl_q.addr;
    assign mem_cre   = ctl_q.pins.cre;
    assign mem_adv_n = ctl_q.pins.adv_n;
    assign mem_cs_n  = ctl_q.pins.cs_n;
    assign mem_oe_n  = ctl_q.pins.oe_n;
    assign mem_lb_n  = ctl_q.pins.bytes_n;
    assign mem_ub_n  = ctl_q.pins.bytes_n;
    assign mem_we_n  = 1'b1;

endmodule

// File: rtl/psram_cfg_reader_chk.sv
module psram_cfg_reader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_sel,
    input logic       req_sync,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       mem_cre,
    input logic       mem_adv_n,
    input logic       mem_cs_n,
    input logic       mem_oe_n,
    input logic       mem_wait_n
);

    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            sync_q <= req_sync;
        end
    end

    // R4 / R5: address latch only happens with the configuration space selected
    assert_adv_with_cre_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> (mem_cre && !mem_cs_n));

    assert_oe_inside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_cs_n);

    assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);

    assert_bad_sel_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_sel == 2'd3) |=> (mem_cs_n && rsp_valid && rsp_err));

    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_capture_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && sync_q) |-> $past(mem_wait_n));

endmodule

bind psram_cfg_reader psram_cfg_reader_chk u_chk (.*);

// File: tb/psram_cfg_reader_bench.sv
module psram_cfg_reader_bench;

    localparam int P_ADV = 2;
    localparam int P_ACC = 3;
    localparam int P_LAT = 3;
    localparam int P_REC = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_sel;
    logic        req_sync;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_err;
    logic [15:0] rsp_data;
    logic [21:0] mem_addr;
    logic        mem_cre, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_in;
    logic        mem_wait_n;

    always #4 clk = ~clk;

    psram_cfg_reader #(
        .ADV_CYC (P_ADV),
        .ACC_CYC (P_ACC),
        .LATENCY (P_LAT),
        .REC_CYC (P_REC)
    ) u_psram_cfg_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_sel    (req_sel),
        .req_sync   (req_sync),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_data   (rsp_data),
        .mem_addr   (mem_addr),
        .mem_cre    (mem_cre),
        .mem_adv_n  (mem_adv_n),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_lb_n   (mem_lb_n),
        .mem_ub_n   (mem_ub_n),
        .mem_dq_in  (mem_dq_in),
        .mem_wait_n (mem_wait_n)
    );

    typedef struct packed {
        logic        cs_n;
        logic        adv_n;
        logic        oe_n;
        logic        cre;
        logic        lb_n;
        logic        ub_n;
        logic        we_n;
        logic [21:0] addr;
        logic        ready;
        logic        rv;
        logic        re;
        logic [15:0] data;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    // memory model state
    logic tb_sync  = 1'b0;
    int   extra_w  = 0;
    int   oe_k     = 0;
    int   cur      = 0;
    logic data_ok;
    exp_t e_now;
    exp_t a_now;
    string t_now;

    function automatic exp_t idle_vec();
        exp_t v;
        v = '{cs_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1, cre: 1'b0, lb_n: 1'b1, ub_n: 1'b1,
              we_n: 1'b1, addr: 22'd0, ready: 1'b1, rv: 1'b0, re: 1'b0, data: 16'h0};
        return v;
    endfunction

    function automatic logic [1:0] code_of(logic [1:0] sel);
        case (sel)
            2'd0: return 2'b00;
            2'd1: return 2'b10;
            default: return 2'b01;
        endcase
    endfunction

    function automatic logic [15:0] expect_val(logic [1:0] sel);
        case (sel)
            2'd0: return 16'h0010;
            2'd1: return 16'h9D4F;
            default: return 16'h0C43;
        endcase
    endfunction

    function automatic logic [15:0] mem_reg(logic [1:0] code);
        case (code)
            2'b00: return 16'h0010;
            2'b10: return 16'h9D4F;
            2'b01: return 16'h0C43;
            default: return 16'h7777;
        endcase
    endfunction

    task automatic push(exp_t v, string tag, int n);
        for (int i = 0; i < n; i++) begin
            q_exp.push_back(v);
            q_tag.push_back(tag);
        end
    endtask

    function automatic exp_t sample_ports();
        exp_t v;
        v = '{cs_n: mem_cs_n, adv_n: mem_adv_n, oe_n: mem_oe_n, cre: mem_cre, lb_n: mem_lb_n,
              ub_n: mem_ub_n, we_n: mem_we_n, addr: mem_addr, ready: req_ready,
              rv: rsp_valid, re: rsp_err, data: rsp_data};
        return v;
    endfunction

    // Per-cycle comparison against the reference queue, then the memory model.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            if (q_exp.size() > 0) begin
                e_now = q_exp.pop_front();
                t_now = q_tag.pop_front();
            end else begin
                e_now = idle_vec();
                t_now = "R9";
            end
            a_now = sample_ports();
            n_checks++;
            if (a_now !== e_now) begin
                n_fail++;
                $display("FAIL %s at %0t: actual %h expected %h", t_now, $time, a_now, e_now);
            end
        end
        if (mem_cs_n === 1'b0 && mem_oe_n === 1'b0) begin
            cur  = oe_k;
            oe_k = oe_k + 1;
        end else begin
            cur  = -1;
            oe_k = 0;
        end
        if (tb_sync && mem_cs_n === 1'b0) begin
            mem_wait_n = (cur >= P_LAT - 1 + extra_w) ? 1'b1 : 1'b0;
        end else begin
            mem_wait_n = 1'b1;
        end
        if (mem_oe_n === 1'b0) begin
            data_ok = tb_sync ? mem_wait_n : (cur >= P_ACC - 1);
            if (mem_cre !== 1'b1) begin
                mem_dq_in = 16'h5A5A;
            end else if (data_ok) begin
                mem_dq_in = mem_reg(mem_addr[19:18]);
            end else begin
                mem_dq_in = 16'hDEAD;
            end
        end else begin
            mem_dq_in = 16'h0000;
        end
    end

    task automatic do_req(logic [1:0] sel, logic sync, int w, bit poke);
        exp_t v;
        logic [21:0] a;
        a = 22'(code_of(sel)) << 18;
        @(posedge clk);
        #2;
        tb_sync = sync;
        extra_w = w;
        push(idle_vec(), "R3", 1);
        if (sel == 2'd3) begin
            v = idle_vec(); v.ready = 1'b0; v.rv = 1'b1; v.re = 1'b1;
            push(v, "R8", 1);
        end else begin
            v = idle_vec(); v.ready = 1'b0; v.cs_n = 1'b0; v.adv_n = 1'b0; v.cre = 1'b1; v.addr = a;
            push(v, sync ? "R5" : "R2", sync ? 1 : P_ADV);
            v.adv_n = 1'b1; v.oe_n = 1'b0; v.lb_n = 1'b0; v.ub_n = 1'b0;
            if (sync) begin
                push(v, "R5", P_LAT);
                push(v, "R6", w);
            end else begin
                push(v, "R4", P_ACC);
            end
            v = idle_vec(); v.ready = 1'b0; v.rv = 1'b1; v.data = expect_val(sel);
            push(v, "R7", 1);
            v.rv = 1'b0; v.data = 16'h0;
            push(v, "R7", P_REC - 1);
        end
        req_valid = 1'b1;
        req_sel   = sel;
        req_sync  = sync;
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        if (poke) begin
            // R3: a request raised mid-access must leave the bus untouched
            @(posedge clk);
            #2;
            req_valid = 1'b1;
            req_sel   = 2'd2;
            req_sync  = ~sync;
            @(posedge clk);
            #2;
            req_valid = 1'b0;
        end
        while (q_exp.size() != 0) @(posedge clk);
    endtask

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_sel    = 2'd0;
        req_sync   = 1'b0;
        mem_dq_in  = 16'h0;
        mem_wait_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (sample_ports() !== idle_vec()) begin
            n_fail++;
            $display("FAIL R1 in reset: actual %h expected %h", sample_ports(), idle_vec());
        end
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        do_req(2'd0, 1'b0, 0, 1'b0);
        do_req(2'd1, 1'b0, 0, 1'b0);
        do_req(2'd2, 1'b0, 0, 1'b0);
        do_req(2'd1, 1'b1, 0, 1'b0);
        do_req(2'd2, 1'b1, 2, 1'b0);
        do_req(2'd0, 1'b1, 1, 1'b0);
        do_req(2'd3, 1'b0, 0, 1'b0);
        do_req(2'd3, 1'b1, 0, 1'b0);
        do_req(2'd0, 1'b0, 0, 1'b1);
        do_req(2'd1, 1'b1, 1, 1'b1);
        do_req(2'd2, 1'b0, 0, 1'b0);
        repeat (4) @(posedge clk);
        #1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule